// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Packed-Decimal Arithmetic

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. On a one-cycle start strobe it takes an operation code, the accumulator value, a second operand, the incoming carry and overflow flags, and a decimal-mode select. One clock later it presents the result byte together with the negative, overflow, zero and carry flags, and it raises a one-cycle done pulse. Between strobes the registered outputs hold their values.

Add-with-carry and subtract-with-borrow work in plain two's-complement binary unless decimal mode is selected. In that case they treat both bytes as two packed BCD digits and apply decimal carry and borrow rules. Compare, the bitwise operations, the shifts and rotates, increment, decrement and bit test always work in binary. Each of these rewrites only the flags that the operation defines, and every other flag passes through from its input. Decimal inputs are assumed to be valid BCD. Invalid nibbles still give a fixed, repeatable result.

Top module: `alu8_core`

## Requirements
- R1: Reset clears the result, all four flags and done. An operation is captured on a clock edge where `start` is 1. Its result and flags appear after that edge and `done` is 1 for exactly that one cycle. While `start` is 0 the result and flags hold.
- R2: Add (code 0, decimal off) gives result = A + B + carry-in modulo 256. C is set when the unsigned sum exceeds 255. V is set when the signed sum falls outside -128..127. N is result bit 7 and Z is set when the result is zero.
- R3: Subtract (code 1, decimal off) is the add of R2 applied to A and the bitwise complement of B, with the same carry input, and it sets flags as in R2.
- R4: Decimal add (code 0, decimal on) gives the packed BCD of (A + B + carry-in) mod 100. C is set when that sum exceeds 99. N and Z follow the result and V holds its input.
- R5: Decimal subtract (code 1, decimal on) gives the packed BCD of A - B - (1 - carry-in), with 100 added when the value is negative. C is set when the value is non-negative. N and Z follow the result and V holds its input.
- R6: Compare (code 2) leaves the result equal to A. C is set when A >= B. N and Z come from the 8-bit difference A - B, and V holds its input.
- R7: AND (code 3), OR (code 4) and XOR (code 5) of A and B set N and Z from the result. C and V hold.
- R8: All four shifts and rotates act on A. Shift-left (code 6) moves bit 7 into C and fills bit 0 with 0. Logical shift-right (code 7) moves bit 0 into C, fills bit 7 with 0 and clears N. Rotate-left (code 8) moves carry-in into bit 0 and bit 7 into C. Rotate-right (code 9) moves carry-in into bit 7 and bit 0 into C. N and Z follow the result, V holds, and the decimal select has no effect.
- R9: Increment (code 10) and decrement (code 11) of A wrap modulo 256 and set N and Z. C and V hold.
- R10: Bit test (code 12) leaves the result equal to A. N takes B bit 7 and V takes B bit 6. Z is set when A AND B is zero, and C holds.
- R11: Codes 13 to 15 pass A to the result and set N and Z from it. C and V hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the operation on this edge |
| op_code | input | 4 | Operation select (codes in R2 to R11) |
| acc_in | input | 8 | Accumulator operand A |
| opr_in | input | 8 | Second operand B |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag |
| dec_mode | input | 1 | Packed-decimal select for add and subtract |
| result | output | 8 | Registered result byte |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Every result, every flag and the done pulse belong to the one clock edge that captures `start`. They are due in the cycle after it, with no further latency for decimal work. The bench applies each operation on a falling edge and holds `start` for one rising edge. It reads outputs on the next falling edge, where done must be 1. It then reads once more a cycle later with new inputs present and `start` low, where the values must be unchanged and done must be 0.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_SHL = 4'd6,
        OP_SHR = 4'd7,
        OP_RTL = 4'd8,
        OP_RTR = 4'd9,
        OP_INC = 4'd10,
        OP_DEC = 4'd11,
        OP_BIT = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu8_bin_add.sv
// Binary add; subtract is the add of the complemented operand.
module alu8_bin_add #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
        sum_o  = wide[MSB:0];
        cout_o = wide[WIDTH];
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu8_bcd_add.sv
// Digit-chained packed-BCD add and subtract.
module alu8_bcd_add #(
    parameter int DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] a_i,
    input  logic [4*DIGITS-1:0] b_i,
    input  logic                cin_i,
    input  logic                sub_i,
    output logic [4*DIGITS-1:0] sum_o,
    output logic                cout_o
);
    logic [DIGITS:0] chain;

    assign chain[0] = sub_i ? ~cin_i : cin_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] da, db, dout;
        logic [4:0] raw;
        logic       nxt;

        assign da = a_i[4*g +: 4];
        assign db = b_i[4*g +: 4];

        always_comb begin
            if (sub_i) begin
                raw = {1'b0, da} - {1'b0, db} - {4'b0, chain[g]};
                nxt = raw[4];
                dout = nxt ? (raw[3:0] + 4'd10) : raw[3:0];
            end else begin
                raw = {1'b0, da} + {1'b0, db} + {4'b0, chain[g]};
                nxt = (raw > 5'd9);
                dout = nxt ? (raw[3:0] - 4'd10) : raw[3:0];
            end
        end

        assign sum_o[4*g +: 4] = dout;
        assign chain[g+1]      = nxt;
    end

    assign cout_o = sub_i ? ~chain[DIGITS] : chain[DIGITS];
endmodule

// File: rtl/alu8_misc_unit.sv
// Logic, shift, rotate, step, compare and bit-test datapath.
module alu8_misc_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic [WIDTH-1:0] nz_src_o,
    output logic             c_o,
    output logic             c_upd_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] diff;

    always_comb begin
        diff     = {1'b0, a_i} - {1'b0, b_i};
        res_o    = a_i;
        nz_src_o = a_i;
        c_o      = cin_i;
        c_upd_o  = 1'b0;
        case (op_i)
            OP_CMP: begin
                nz_src_o = diff[MSB:0];
                c_o      = ~diff[WIDTH];
                c_upd_o  = 1'b1;
            end
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_SHL: begin
                res_o   = {a_i[MSB-1:0], 1'b0};
                c_o     = a_i[MSB];
                c_upd_o = 1'b1;
            end
            OP_SHR: begin
                res_o   = {1'b0, a_i[MSB:1]};
                c_o     = a_i[0];
                c_upd_o = 1'b1;
            end
            OP_RTL: begin
                res_o   = {a_i[MSB-1:0], cin_i};
                c_o     = a_i[MSB];
                c_upd_o = 1'b1;
            end
            OP_RTR: begin
                res_o   = {cin_i, a_i[MSB:1]};
                c_o     = a_i[0];
                c_upd_o = 1'b1;
            end
            OP_INC: res_o = a_i + 1'b1;
            OP_DEC: res_o = a_i - 1'b1;
            OP_BIT: nz_src_o = a_i & b_i;
            default: res_o = a_i;
        endcase
        if (op_i != OP_CMP && op_i != OP_BIT) begin
            nz_src_o = res_o;
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] opr_in,
    input  logic             carry_in,
    input  logic             ovf_in,
    input  logic             dec_mode,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_c,
    output logic             done
);
    localparam int MSB    = WIDTH - 1;
    localparam int DIGITS = WIDTH / 4;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        alu_flags_t       flg;
        logic             done;
    } core_state_t;

    core_state_t st_d, st_q;

    logic             is_arith, is_sub;
    logic [WIDTH-1:0] bin_sum, bcd_sum, misc_res, misc_nz;
    logic             bin_c, bin_v, bcd_c, misc_c, misc_cupd;

    assign is_arith = (op_code == OP_ADD) || (op_code == OP_SUB);
    assign is_sub   = (op_code == OP_SUB);

    alu8_bin_add #(.WIDTH(WIDTH)) u_bin (
        .a_i(acc_in), .b_i(opr_in), .cin_i(carry_in), .sub_i(is_sub),
        .sum_o(bin_sum), .cout_o(bin_c), .ovf_o(bin_v)
    );

    alu8_bcd_add #(.DIGITS(DIGITS)) u_bcd (
        .a_i(acc_in), .b_i(opr_in), .cin_i(carry_in), .sub_i(is_sub),
        .sum_o(bcd_sum), .cout_o(bcd_c)
    );

    alu8_misc_unit #(.WIDTH(WIDTH)) u_misc (
        .op_i(op_code), .a_i(acc_in), .b_i(opr_in), .cin_i(carry_in),
        .res_o(misc_res), .nz_src_o(misc_nz), .c_o(misc_c), .c_upd_o(misc_cupd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.done = 1'b1;
            if (is_arith) begin
                st_d.res   = dec_mode ? bcd_sum : bin_sum;
                st_d.flg.c = dec_mode ? bcd_c : bin_c;
                st_d.flg.v = dec_mode ? ovf_in : bin_v;
                st_d.flg.n = st_d.res[MSB];
                st_d.flg.z = (st_d.res == '0);
            end else begin
                st_d.res   = misc_res;
                st_d.flg.c = misc_cupd ? misc_c : carry_in;
                st_d.flg.v = (op_code == OP_BIT) ? opr_in[MSB-1] : ovf_in;
                st_d.flg.n = (op_code == OP_BIT) ? opr_in[MSB]
                           : (op_code == OP_SHR) ? 1'b0 : misc_nz[MSB];
                st_d.flg.z = (misc_nz == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.res;
    assign flag_n = st_q.flg.n;
    assign flag_v = st_q.flg.v;
    assign flag_z = st_q.flg.z;
    assign flag_c = st_q.flg.c;
    assign done   = st_q.done;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [3:0]       op_code,
    input logic [WIDTH-1:0] acc_in,
    input logic [WIDTH-1:0] opr_in,
    input logic             carry_in,
    input logic             ovf_in,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_v,
    input logic             flag_z,
    input logic             flag_c,
    input logic             done
);
    a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(flag_c) && $stable(flag_z)));
    a_r6_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_code == 4'd2) |=> (flag_c == ($past(acc_in) >= $past(opr_in))
                                        && flag_v == $past(ovf_in)));
    a_r8_shr_clears_n: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_code == 4'd7) |=> (!flag_n && flag_c == $past(acc_in[0])));
    a_r9_step_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op_code == 4'd10 || op_code == 4'd11))
            |=> (flag_c == $past(carry_in) && flag_v == $past(ovf_in)));
    a_r10_bit_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_code == 4'd12) |=> (flag_n == $past(opr_in[WIDTH-1])
            && flag_v == $past(opr_in[WIDTH-2]) && result == $past(acc_in)));
    a_r7_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_code >= 4'd3 && op_code <= 4'd5) |=> (flag_z == (result == '0)));
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .acc_in(acc_in), .opr_in(opr_in), .carry_in(carry_in), .ovf_in(ovf_in),
    .result(result), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
    .flag_c(flag_c), .done(done)
);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0, opr_in = '0;
    logic       carry_in = 1'b0, ovf_in = 1'b0, dec_mode = 1'b0;
    logic [7:0] result;
    logic       flag_n, flag_v, flag_z, flag_c, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .acc_in(acc_in), .opr_in(opr_in), .carry_in(carry_in), .ovf_in(ovf_in),
        .dec_mode(dec_mode), .result(result), .flag_n(flag_n), .flag_v(flag_v),
        .flag_z(flag_z), .flag_c(flag_c), .done(done)
    );

    // {op, A, B, cin, vin, dec, expected result, expected nvzc}
    localparam int NV = 28;
    localparam logic [34:0] VEC [NV] = '{
        {4'd0,  8'h50, 8'h50, 3'b000, 8'hA0, 4'b1100},  // R2 signed overflow
        {4'd0,  8'hFF, 8'h01, 3'b000, 8'h00, 4'b0011},  // R2 carry out, zero
        {4'd0,  8'h7F, 8'h00, 3'b100, 8'h80, 4'b1100},  // R2 carry in
        {4'd1,  8'h50, 8'hF0, 3'b100, 8'h60, 4'b0000},  // R3
        {4'd1,  8'h50, 8'hB0, 3'b100, 8'hA0, 4'b1100},  // R3 overflow
        {4'd1,  8'h05, 8'h03, 3'b000, 8'h01, 4'b0001},  // R3 borrow in
        {4'd0,  8'h58, 8'h46, 3'b111, 8'h05, 4'b0101},  // R4 carry, V held
        {4'd0,  8'h99, 8'h01, 3'b001, 8'h00, 4'b0011},  // R4 wrap to zero
        {4'd0,  8'h12, 8'h34, 3'b001, 8'h46, 4'b0000},  // R4 plain
        {4'd1,  8'h46, 8'h12, 3'b101, 8'h34, 4'b0001},  // R5 plain
        {4'd1,  8'h12, 8'h21, 3'b111, 8'h91, 4'b1100},  // R5 negative, V held
        {4'd1,  8'h50, 8'h49, 3'b011, 8'h00, 4'b0111},  // R5 borrow to zero
        {4'd2,  8'h40, 8'h40, 3'b010, 8'h40, 4'b0111},  // R6 equal
        {4'd2,  8'h10, 8'h20, 3'b000, 8'h10, 4'b1000},  // R6 less
        {4'd3,  8'hF0, 8'h0F, 3'b110, 8'h00, 4'b0111},  // R7 AND
        {4'd4,  8'h80, 8'h01, 3'b000, 8'h81, 4'b1000},  // R7 OR
        {4'd5,  8'hFF, 8'h0F, 3'b100, 8'hF0, 4'b1001},  // R7 XOR
        {4'd6,  8'h81, 8'h00, 3'b000, 8'h02, 4'b0001},  // R8 shift left
        {4'd7,  8'h01, 8'h00, 3'b110, 8'h00, 4'b0111},  // R8 shift right
        {4'd8,  8'h80, 8'h00, 3'b100, 8'h01, 4'b0001},  // R8 rotate left
        {4'd9,  8'h01, 8'h00, 3'b100, 8'h80, 4'b1001},  // R8 rotate right
        {4'd9,  8'h02, 8'h00, 3'b000, 8'h01, 4'b0000},  // R8 rotate right no C
        {4'd6,  8'h40, 8'h00, 3'b001, 8'h80, 4'b1000},  // R8 decimal ignored
        {4'd10, 8'hFF, 8'h00, 3'b010, 8'h00, 4'b0110},  // R9 increment wrap
        {4'd11, 8'h00, 8'h00, 3'b100, 8'hFF, 4'b1001},  // R9 decrement wrap
        {4'd12, 8'h0F, 8'hC0, 3'b100, 8'h0F, 4'b1111},  // R10 disjoint
        {4'd12, 8'h01, 8'h01, 3'b010, 8'h01, 4'b0000},  // R10 overlap
        {4'd13, 8'h5A, 8'h00, 3'b110, 8'h5A, 4'b0101}   // R11 spare code
    };

    function automatic int req_of(input logic [3:0] op, input logic dm);
        case (op)
            4'd0: return dm ? 4 : 2;
            4'd1: return dm ? 5 : 3;
            4'd2: return 6;
            4'd3, 4'd4, 4'd5: return 7;
            4'd6, 4'd7, 4'd8, 4'd9: return 8;
            4'd10, 4'd11: return 9;
            4'd12: return 10;
            default: return 11;
        endcase
    endfunction

    task automatic check(input int req, input logic [12:0] got, input logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: got res=%h nvzc=%b done=%b, expected res=%h nvzc=%b done=%b",
                     req, got[12:5], got[4:1], got[0], exp[12:5], exp[4:1], exp[0]);
        end
    endtask

    function automatic logic [12:0] outs();
        return {result, flag_n, flag_v, flag_z, flag_c, done};
    endfunction

    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] cvd);
        @(negedge clk);
        op_code = op; acc_in = a; opr_in = b;
        {carry_in, ovf_in, dec_mode} = cvd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R1: watchdog expired, got no end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [12:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(1, outs(), 13'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, outs(), 13'h0);

        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            v = VEC[i];
            apply(v[34:31], v[30:23], v[22:15], v[14:12]);
            check(req_of(v[34:31], v[12]), outs(), {v[11:0], 1'b1});
        end

        // R1: outputs hold with start low while inputs change, done drops
        apply(4'd0, 8'h21, 8'h13, 3'b000);
        held = outs();
        check(2, held, {8'h34, 4'b0000, 1'b1});
        op_code = 4'd11; acc_in = 8'h00; opr_in = 8'hFF; carry_in = 1'b1; ovf_in = 1'b1;
        @(negedge clk);
        check(1, outs(), {held[12:1], 1'b0});
        @(negedge clk);
        check(1, outs(), {held[12:1], 1'b0});

        // R1: back-to-back strobes each give their own result
        @(negedge clk);
        op_code = 4'd10; acc_in = 8'h7F; carry_in = 1'b0; ovf_in = 1'b0; dec_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        check(9, outs(), {8'h80, 4'b1000, 1'b1});
        op_code = 4'd7; acc_in = 8'h80;
        @(negedge clk);
        start = 1'b0;
        check(8, outs(), {8'h40, 4'b0000, 1'b1});
        @(negedge clk);
        check(1, outs(), {8'h40, 4'b0000, 1'b0});

        // R1: reset in mid-run clears again
        rst_n = 1'b0;
        @(negedge clk);
        check(1, outs(), 13'h0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule